// File: doc/BRIEF.md
# Coarse/Fine Frequency Detector Pulse Combiner

This block sits between two frequency detectors and the single charge pump of a frequency-acquisition loop. A coarse detector and a fine detector both run continuously, and each produces its own pair of increase/decrease pulses. The combiner merges the two pairs into one increase/decrease pair, so the detectors never take turns.

A one-bit direction register decides which coarse pulse is merged. While the register is clear, the data is taken to be slower than the clock. In that state the coarse decrease pulse is ORed with the fine decrease pulse, and the increase output carries only the fine increase pulse. The first rising edge of the coarse increase pulse sets the register, and it then stays set until reset. Once set, the coarse increase pulse is ORed into the increase output, and the decrease output carries only the fine pulse. Close to lock the coarse detector goes quiet, so only the fine pulses reach the pump.

All inputs are sampled on the block clock. The merged outputs are registered, so they have one cycle of latency. An enable input deselects the frequency loop.

Top module: `fd_pulse_combiner`

## Requirements
- R1: While `rst_n` is low, `pump_up`, `pump_dn` and `dir_fast` are 0, and the direction register comes out of reset at 0.
- R2: With `dir_fast` = 0 and `loop_en` = 1, `pump_up` in the next cycle equals `fin_up`, and `crs_up` has no effect on it.
- R3: With `dir_fast` = 0 and `loop_en` = 1, `pump_dn` in the next cycle equals `crs_dn` OR `fin_dn`.
- R4: With `dir_fast` = 1 and `loop_en` = 1, `pump_up` in the next cycle equals `crs_up` OR `fin_up`.
- R5: With `dir_fast` = 1 and `loop_en` = 1, `pump_dn` in the next cycle equals `fin_dn`, and `crs_dn` has no effect on it.
- R6: `dir_fast` becomes 1 in the cycle after a rising edge of `crs_up` is sampled while `loop_en` = 1. A rising edge means `crs_up` was 0 at the previous clock and is 1 at this one. Once set, `dir_fast` stays 1 until reset. The merge in the cycle of that edge still uses the old direction value.
- R7: When `loop_en` = 0, `pump_up` and `pump_dn` are 0 in the next cycle, and `dir_fast` does not change.
- R8: The outputs are registered. A one-cycle pulse on a fine input shows on its output exactly one clock later, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| loop_en | input | 1 | Frequency loop selected |
| crs_up | input | 1 | Coarse detector increase pulse |
| crs_dn | input | 1 | Coarse detector decrease pulse |
| fin_up | input | 1 | Fine detector increase pulse |
| fin_dn | input | 1 | Fine detector decrease pulse |
| pump_up | output | 1 | Merged increase pulse to the charge pump |
| pump_dn | output | 1 | Merged decrease pulse to the charge pump |
| dir_fast | output | 1 | Direction flag; 1 means data is faster than the clock |

## Verification
The hardest state to reach is a set direction flag with coarse decrease pulses still arriving. The register is sticky and can only be set by an enabled rising edge of the coarse increase pulse. For this reason the bench sweeps every input combination twice. The first pass starts from a fresh reset. The second pass first inserts one enabled coarse-increase cycle, so that the flag is already set. The sweep also covers a coarse increase edge while the loop is disabled, and an edge arriving in the same cycle as the merge it must not yet affect.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    typedef struct packed {
        logic prev_up;
        logic fast;
    } dir_state_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_state_t;

endpackage

// File: rtl/fdc_dir_track.sv
module fdc_dir_track
    import fdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic crs_up,
    output logic fast
);

    dir_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.prev_up = crs_up;
        if (en && crs_up && !st_q.prev_up) begin
            st_d.fast = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fast = st_q.fast;

    // R6: the flag never clears once set
    a_r6_dir_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fast |=> st_q.fast);

    // R7: a disabled cycle leaves the flag unchanged
    a_r7_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.fast));

endmodule

// File: rtl/fdc_merge.sv
module fdc_merge
    import fdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fast,
    input  logic crs_up,
    input  logic crs_dn,
    input  logic fin_up,
    input  logic fin_dn,
    output logic up,
    output logic dn
);

    pump_state_t p_d, p_q;

    always_comb begin
        p_d = '0;
        if (en) begin
            if (fast) begin
                p_d.up = crs_up | fin_up;
                p_d.dn = fin_dn;
            end else begin
                p_d.up = fin_up;
                p_d.dn = crs_dn | fin_dn;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign up = p_q.up;
    assign dn = p_q.dn;

    // R2: slow direction, coarse up cannot reach the pump
    a_r2_slow_up_fine_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast && !fin_up) |=> !p_q.up);

    // R3: slow direction, coarse dn reaches the pump
    a_r3_slow_dn_coarse: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !fast && crs_dn) |=> p_q.dn);

    // R4: fast direction, coarse up reaches the pump
    a_r4_fast_up_coarse: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fast && crs_up) |=> p_q.up);

    // R5: fast direction, coarse dn cannot reach the pump
    a_r5_fast_dn_fine_only: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && !fin_dn) |=> !p_q.dn);

    // R7: disabled loop gives quiet outputs
    a_r7_en_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!p_q.up && !p_q.dn));

endmodule

// File: rtl/fd_pulse_combiner.sv
module fd_pulse_combiner
    import fdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic crs_up,
    input  logic crs_dn,
    input  logic fin_up,
    input  logic fin_dn,
    output logic pump_up,
    output logic pump_dn,
    output logic dir_fast
);

    logic fast_w;

    fdc_dir_track dir_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (loop_en),
        .crs_up (crs_up),
        .fast   (fast_w)
    );

    fdc_merge merge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (loop_en),
        .fast   (fast_w),
        .crs_up (crs_up),
        .crs_dn (crs_dn),
        .fin_up (fin_up),
        .fin_dn (fin_dn),
        .up     (pump_up),
        .dn     (pump_dn)
    );

    assign dir_fast = fast_w;

    // R1: reset holds everything low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!pump_up && !pump_dn && !dir_fast));

    // R6: the flag only rises after an enabled coarse up sample
    a_r6_dir_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir_fast) |-> $past(loop_en && crs_up));

endmodule

// File: tb/fd_pulse_combiner_tb_top.sv
module fd_pulse_combiner_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loop_en = 1'b0, crs_up = 1'b0, crs_dn = 1'b0, fin_up = 1'b0, fin_dn = 1'b0;
    logic pump_up, pump_dn, dir_fast;

    int checks = 0;
    int errors = 0;
    bit m_fast, m_prev, e_up, e_dn;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fd_pulse_combiner dut_i (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en),
        .crs_up(crs_up), .crs_dn(crs_dn), .fin_up(fin_up), .fin_dn(fin_dn),
        .pump_up(pump_up), .pump_dn(pump_dn), .dir_fast(dir_fast)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Called at a negedge; drives a vector, waits for the edge, compares.
    task automatic apply(input logic [4:0] v, input bit check);
        string tag_up, tag_dn;
        {loop_en, crs_up, crs_dn, fin_up, fin_dn} = v;
        @(posedge clk);
        if (!v[4]) begin
            e_up = 0; e_dn = 0; tag_up = "R7"; tag_dn = "R7";
        end else if (m_fast) begin
            e_up = v[3] | v[1]; e_dn = v[0]; tag_up = "R4"; tag_dn = "R5";
        end else begin
            e_up = v[1]; e_dn = v[2] | v[0]; tag_up = "R2"; tag_dn = "R3";
        end
        if (v[4] && v[3] && !m_prev) m_fast = 1;
        m_prev = v[3];
        @(negedge clk);
        if (check) begin
            chk(tag_up, pump_up, e_up);
            chk(tag_dn, pump_dn, e_dn);
            chk("R6", dir_fast, m_fast);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {loop_en, crs_up, crs_dn, fin_up, fin_dn} = '0;
        m_fast = 0; m_prev = 0;
        @(negedge clk);
        chk("R1", pump_up, 1'b0);
        chk("R1", pump_dn, 1'b0);
        chk("R1", dir_fast, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // pass 0: fresh direction; pass 1: direction preset by a coarse up edge
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < 32; v++) begin
                do_reset();
                if (pass == 1) begin
                    apply(5'b11000, 1'b0);
                    apply(5'b10000, 1'b0);
                    chk("R6", dir_fast, 1'b1);
                end
                apply(v[4:0], 1'b1);
                apply(5'b10000, 1'b1);
            end
        end
        // R7: a coarse up edge while disabled must not set the direction
        do_reset();
        apply(5'b01000, 1'b1);
        apply(5'b11000, 1'b1);   // still high: no new edge, so no set
        chk("R7", dir_fast, 1'b0);
        // R8: single-cycle fine pulse appears one clock later for one cycle
        do_reset();
        {loop_en, crs_up, crs_dn, fin_up, fin_dn} = 5'b10010;
        @(posedge clk); #1;
        chk("R8", pump_up, 1'b1);
        @(negedge clk);
        {loop_en, crs_up, crs_dn, fin_up, fin_dn} = 5'b10000;
        @(posedge clk); #1;
        chk("R8", pump_up, 1'b0);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule